// File: doc/BRIEF.md
# Hypervisor-Aware Interrupt Pending Selector

This block decides, once per clock, whether a hart that implements the hypervisor extension has an interrupt to take, and which cause number to take. It receives the current privilege code, the virtualization flag, the machine and supervisor global interrupt enable bits, and four XLEN-wide vectors: pending interrupts, enabled interrupts, the machine-to-supervisor delegation mask and the supervisor-to-guest delegation mask.

Each pending and enabled bit is sent to one of three levels. A bit with no machine delegation goes to machine level. A bit delegated by the machine mask but not by the guest mask goes to the hypervisor-supervisor level. A bit delegated by both masks goes to the guest-supervisor level. Each level is then gated by its effective global enable. A level that is more privileged than the one currently running is always enabled. The lowest-numbered surviving bit becomes the cause.

The result is registered, so a decision appears one cycle after its inputs. Trap entry, CSR updates and the CSR storage sit outside this block.

Top module: `hyp_irq_select`

## Requirements
- R1: A synchronous active-high reset clears the take flag and the cause output to 0 at the next rising edge.
- R2: A bit can be selected only when it is set in both the pending vector and the enable vector.
- R3: Privilege codes are 0 = user, 1 = supervisor, 3 = machine, and 2 is reserved. The machine-level enable is true for codes 0 and 1, and for code 3 only when the machine global enable bit is 1. It is false for code 2.
- R4: The supervisor effective enable is true for code 0, and for code 1 only when the supervisor global enable bit is 1. It is false for codes 2 and 3.
- R5: A bit delegated by the machine mask and not by the guest mask is enabled when the virtualization flag is 1 or the supervisor effective enable is true.
- R6: A bit delegated by both masks is enabled only when the virtualization flag is 1 and the supervisor effective enable is true.
- R7: A bit with no machine delegation is routed to machine level whatever the virtualization flag is. This includes the guest interrupt positions 2, 6 and 10.
- R8: When more than one bit survives, the cause is the index of the lowest-numbered one, and the take flag is 1.
- R9: When no bit survives, the take flag is 0 and the cause is 0.
- R10: Outputs change exactly one rising edge after the inputs change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| privI | input | 2 | Current privilege code (0 U, 1 S, 3 M, 2 reserved) |
| virtI | input | 1 | Virtualization flag |
| mGlobIeI | input | 1 | Machine global interrupt enable |
| sGlobIeI | input | 1 | Supervisor global interrupt enable |
| intPendI | input | XLEN | Pending interrupt vector |
| intEnI | input | XLEN | Per-interrupt enable vector |
| delegMI | input | XLEN | Machine-to-supervisor delegation mask |
| delegVI | input | XLEN | Supervisor-to-guest delegation mask |
| takeO | output | 1 | An interrupt should be taken |
| causeO | output | $clog2(XLEN) | Chosen cause index |

## Verification
The bench builds the block with XLEN set to 16 and a 4-bit cause. This still covers the guest interrupt positions 2, 6 and 10 and every bit position up to the top of the vector. With the narrower vector, the bench sweeps every combination of the four privilege codes, the virtualization flag and both global enable bits, against pseudo-random vector patterns. Directed cases cover the reserved privilege code, the routing of undelegated guest bits, lowest-index priority and the one-cycle latency.

// File: rtl/hyp_irq_pkg.sv
package hyp_irq_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Per-level effective global enables, control -> datapath
  typedef struct packed {
    logic mEn;
    logic hsEn;
    logic vsEn;
  } lvl_en_t;

endpackage

// File: rtl/hyp_irq_ctl.sv
module hyp_irq_ctl
  import hyp_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic [1:0] privI,
  input  logic    virtI,
  input  logic    mGlobIeI,
  input  logic    sGlobIeI,
  output lvl_en_t strbO
);

  priv_e privCur;
  logic  belowMach;
  logic  belowSuper;
  logic  sEff;

  assign privCur = priv_e'(privI);

  always_comb begin
    belowMach  = 1'b0;
    belowSuper = 1'b0;
    unique case (privCur)
      PRIV_USER:  begin belowMach = 1'b1; belowSuper = 1'b1; end
      PRIV_SUPER: begin belowMach = 1'b1; belowSuper = 1'b0; end
      default:    begin belowMach = 1'b0; belowSuper = 1'b0; end
    endcase
  end

  assign sEff = belowSuper || ((privCur == PRIV_SUPER) && sGlobIeI);

  always_comb begin
    strbO.mEn  = belowMach || ((privCur == PRIV_MACH) && mGlobIeI);
    // hypervisor level outranks any virtualized mode
    strbO.hsEn = virtI || sEff;
    strbO.vsEn = virtI && sEff;
  end

  AST_RSVD_NO_MEN: assert property (@(posedge clk) disable iff (rst)
    (privI == 2'd2) |-> !strbO.mEn); // R3
  AST_VS_IMPLIES_HS: assert property (@(posedge clk) disable iff (rst)
    strbO.vsEn |-> strbO.hsEn); // R6
  AST_MACH_LOCKS_S: assert property (@(posedge clk) disable iff (rst)
    (privI == 2'd3 && !virtI) |-> !strbO.hsEn); // R4

endmodule

// File: rtl/hyp_irq_dp.sv
module hyp_irq_dp
  import hyp_irq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  lvl_en_t            strbI,
  input  logic [XLEN-1:0]    intPendI,
  input  logic [XLEN-1:0]    intEnI,
  input  logic [XLEN-1:0]    delegMI,
  input  logic [XLEN-1:0]    delegVI,
  output logic               takeO,
  output logic [CAUSE_W-1:0] causeO
);

  localparam int NUM_LVL = 3;
  localparam logic [XLEN-1:0] ONE_V = XLEN'(1);

  logic [XLEN-1:0]    pendVec;
  logic [XLEN-1:0]    lvlRaw   [NUM_LVL];
  logic [NUM_LVL-1:0] lvlOn;
  logic [XLEN-1:0]    lvlMask  [NUM_LVL];
  logic [XLEN-1:0]    selVec;
  logic [CAUSE_W-1:0] lowIdx;
  logic               anySel;
  logic               takeQ;
  logic [CAUSE_W-1:0] causeQ;

  assign pendVec   = intPendI & intEnI;
  assign lvlRaw[0] = pendVec & ~delegMI;
  assign lvlRaw[1] = pendVec &  delegMI & ~delegVI;
  assign lvlRaw[2] = pendVec &  delegMI &  delegVI;
  assign lvlOn     = {strbI.vsEn, strbI.hsEn, strbI.mEn};

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvlMask[g] = lvlRaw[g] & {XLEN{lvlOn[g]}};
  end

  always_comb begin
    selVec = '0;
    for (int k = 0; k < NUM_LVL; k++) selVec = selVec | lvlMask[k];
  end

  assign anySel = |selVec;

  always_comb begin
    lowIdx = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (selVec[i]) lowIdx = CAUSE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      takeQ  <= 1'b0;
      causeQ <= '0;
    end else begin
      takeQ  <= anySel;
      causeQ <= anySel ? lowIdx : '0;
    end
  end

  assign takeO  = takeQ;
  assign causeO = causeQ;

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!takeQ && causeQ == '0)); // R1
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !anySel |=> (!takeQ && causeQ == '0)); // R9
  AST_FOUND_TAKE: assert property (@(posedge clk) disable iff (rst)
    anySel |=> takeQ); // R10
  AST_CAUSE_PENDING: assert property (@(posedge clk) disable iff (rst)
    takeQ |-> ((($past(pendVec) >> causeQ) & ONE_V) != '0)); // R2
  AST_CAUSE_LOWEST: assert property (@(posedge clk) disable iff (rst)
    takeQ |-> (($past(selVec) & ((ONE_V << causeQ) - ONE_V)) == '0)); // R8

endmodule

// File: rtl/hyp_irq_select.sv
module hyp_irq_select
  import hyp_irq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         privI,
  input  logic               virtI,
  input  logic               mGlobIeI,
  input  logic               sGlobIeI,
  input  logic [XLEN-1:0]    intPendI,
  input  logic [XLEN-1:0]    intEnI,
  input  logic [XLEN-1:0]    delegMI,
  input  logic [XLEN-1:0]    delegVI,
  output logic               takeO,
  output logic [CAUSE_W-1:0] causeO
);

  lvl_en_t lvlStrb;

  hyp_irq_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .privI    (privI),
    .virtI    (virtI),
    .mGlobIeI (mGlobIeI),
    .sGlobIeI (sGlobIeI),
    .strbO    (lvlStrb)
  );

  hyp_irq_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strbI    (lvlStrb),
    .intPendI (intPendI),
    .intEnI   (intEnI),
    .delegMI  (delegMI),
    .delegVI  (delegVI),
    .takeO    (takeO),
    .causeO   (causeO)
  );

endmodule

// File: tb/hyp_irq_select_bench.sv
module hyp_irq_select_bench;

  localparam int XLEN = 16;
  localparam int CW   = $clog2(XLEN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] privI = '0;
  logic virtI = 1'b0, mGlobIeI = 1'b0, sGlobIeI = 1'b0;
  logic [XLEN-1:0] intPendI = '0, intEnI = '0, delegMI = '0, delegVI = '0;
  logic takeO;
  logic [CW-1:0] causeO;

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  hyp_irq_select #(.XLEN(XLEN)) u_hyp_irq_select (
    .clk(clk), .rst(rst), .privI(privI), .virtI(virtI),
    .mGlobIeI(mGlobIeI), .sGlobIeI(sGlobIeI), .intPendI(intPendI),
    .intEnI(intEnI), .delegMI(delegMI), .delegVI(delegVI),
    .takeO(takeO), .causeO(causeO)
  );

  // Expected result from the requirements
  function automatic logic [CW:0] model(
    input logic [1:0] p, input logic v, input logic mg, input logic sg,
    input logic [XLEN-1:0] ip, input logic [XLEN-1:0] ie,
    input logic [XLEN-1:0] dm, input logic [XLEN-1:0] dv);
    logic mE, sE, hE, vE;
    logic [XLEN-1:0] pend, sel;
    logic [CW-1:0] c;
    mE = (p == 2'd0) || (p == 2'd1) || (p == 2'd3 && mg);
    sE = (p == 2'd0) || (p == 2'd1 && sg);
    hE = v || sE;
    vE = v && sE;
    pend = ip & ie;
    sel = (mE ? (pend & ~dm) : '0) | (hE ? (pend & dm & ~dv) : '0) |
          (vE ? (pend & dm & dv) : '0);
    c = '0;
    for (int i = XLEN - 1; i >= 0; i--) if (sel[i]) c = CW'(i);
    return {(sel != '0), c};
  endfunction

  task automatic check(input string tag, input logic expT, input logic [CW-1:0] expC);
    checks++;
    if (takeO !== expT || causeO !== expC) begin
      errors++;
      $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
               tag, takeO, causeO, expT, expC);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic v, input logic mg, input logic sg,
                       input logic [XLEN-1:0] ip, input logic [XLEN-1:0] ie,
                       input logic [XLEN-1:0] dm, input logic [XLEN-1:0] dv);
    @(negedge clk);
    privI = p; virtI = v; mGlobIeI = mg; sGlobIeI = sg;
    intPendI = ip; intEnI = ie; delegMI = dm; delegVI = dv;
  endtask

  task automatic runCase(input string tag, input logic [1:0] p, input logic v,
                         input logic mg, input logic sg,
                         input logic [XLEN-1:0] ip, input logic [XLEN-1:0] ie,
                         input logic [XLEN-1:0] dm, input logic [XLEN-1:0] dv);
    logic [CW:0] e;
    e = model(p, v, mg, sg, ip, ie, dm, dv);
    drive(p, v, mg, sg, ip, ie, dm, dv);
    @(negedge clk);
    check(tag, e[CW], e[CW-1:0]);
  endtask

  function automatic logic [31:0] nextRng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset with live stimulus
    privI = 2'd0; intPendI = '1; intEnI = '1;
    @(negedge clk); @(negedge clk);
    check("R1", 1'b0, '0);
    rst = 1'b0;

    // R7: undelegated guest bits reach machine level with V=0
    runCase("R7", 2'd3, 1'b0, 1'b1, 1'b0, 16'h0004, 16'hFFFF, 16'h0000, 16'h0000);
    check("R7", 1'b1, 4'd2);
    runCase("R7", 2'd3, 1'b0, 1'b1, 1'b0, 16'h0040, 16'hFFFF, 16'h0000, 16'h0000);
    check("R7", 1'b1, 4'd6);
    runCase("R7", 2'd1, 1'b0, 1'b0, 1'b0, 16'h0400, 16'hFFFF, 16'h0000, 16'h0000);
    check("R7", 1'b1, 4'd10);

    // R2: pending without enable is ignored
    runCase("R2", 2'd0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000);
    check("R2", 1'b0, 4'd0);
    runCase("R2", 2'd0, 1'b0, 1'b0, 1'b0, 16'h0F00, 16'h0A00, 16'h0000, 16'h0000);
    check("R2", 1'b1, 4'd9);

    // R3: reserved code masks machine level; M with MIE=0 masks it
    runCase("R3", 2'd2, 1'b0, 1'b1, 1'b1, 16'h0080, 16'hFFFF, 16'h0000, 16'h0000);
    check("R3", 1'b0, 4'd0);
    runCase("R3", 2'd3, 1'b0, 1'b0, 1'b1, 16'h0080, 16'hFFFF, 16'h0000, 16'h0000);
    check("R3", 1'b0, 4'd0);

    // R4: supervisor level masked at S with SIE=0, open at U
    runCase("R4", 2'd1, 1'b0, 1'b0, 1'b0, 16'h0020, 16'hFFFF, 16'h0020, 16'h0000);
    check("R4", 1'b0, 4'd0);
    runCase("R4", 2'd0, 1'b0, 1'b0, 1'b0, 16'h0020, 16'hFFFF, 16'h0020, 16'h0000);
    check("R4", 1'b1, 4'd5);

    // R5: hypervisor level open under V even at S with SIE=0
    runCase("R5", 2'd1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'hFFFF, 16'h0200, 16'h0000);
    check("R5", 1'b1, 4'd9);

    // R6: guest level needs V and supervisor enable
    runCase("R6", 2'd0, 1'b0, 1'b0, 1'b0, 16'h0004, 16'hFFFF, 16'h0004, 16'h0004);
    check("R6", 1'b0, 4'd0);
    runCase("R6", 2'd0, 1'b1, 1'b0, 1'b0, 16'h0004, 16'hFFFF, 16'h0004, 16'h0004);
    check("R6", 1'b1, 4'd2);

    // R8: lowest index wins
    runCase("R8", 2'd0, 1'b0, 1'b0, 1'b0, 16'h8890, 16'hFFFF, 16'h0000, 16'h0000);
    check("R8", 1'b1, 4'd4);

    // R10: outputs hold until the next edge
    drive(2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    #1 check("R10", 1'b1, 4'd4);
    @(negedge clk);
    check("R10", 1'b0, 4'd0);

    // R9: empty result
    runCase("R9", 2'd3, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    check("R9", 1'b0, 4'd0);

    // Sweep all control combinations against pseudo-random vectors (R5, R8)
    for (int ctl = 0; ctl < 32; ctl++) begin
      for (int n = 0; n < 24; n++) begin
        logic [XLEN-1:0] a, b, c, d;
        rng = nextRng(rng); a = rng[15:0]; b = rng[31:16];
        rng = nextRng(rng); c = rng[15:0]; d = rng[31:16];
        runCase("R5/R8 sweep", ctl[4:3], ctl[2], ctl[1], ctl[0], a, b | 16'h0444, c, d);
      end
    end

    // R1: reset mid-run clears a live decision
    drive(2'd0, 1'b0, 1'b0, 1'b0, 16'h0008, 16'hFFFF, 16'h0000, 16'h0000);
    @(negedge clk);
    check("R1", 1'b1, 4'd3);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 4'd0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule